// File: doc/BRIEF.md
# Flash Array Idle Power Controller

This block decides when the supply rail of a multi-bank flash array is on. It runs from a slow time-base pulse (`tick_i`, nominally one per millisecond) and measures how long it has been since the array was last used. When the array has been quiet for too long, it turns off the rail and returns the pads to their low-power state. Idleness is judged only at coarse sampling points, once every `POLL_TICKS` ticks, and not at every tick.

When an access request arrives while the rail is off, the block starts a full power-up. It turns on the rail and waits `SETTLE_TICKS` ticks for the supply to settle. It then enables the pads and asks the command sequencer to reset each populated bank, one at a time, in ascending bank order. Power-ready is raised only after the last of those resets has finished. If the sequencer reports a failed reset, the block latches a fatal flag and stops. It leaves the rail on and never raises power-ready until the block is reset.

Top module: `flash_idle_pwr`

## Requirements
- R1: After `rst_n` is released, `rail_en_o`, `pad_en_o`, `rst_req_o`, `pwr_ready_o` and `fatal_o` are all 0, and `rst_bank_o` is 0.
- R2: If `req_i` is 1 while the rail is off, `rail_en_o` is 1 at the next clock. `pad_en_o` and `pwr_ready_o` stay 0 at that point.
- R3: After the rail turns on, `pad_en_o` stays 0 and no reset request is made until `SETTLE_TICKS` ticks have been received in the settling phase. `pad_en_o` rises at the clock that takes the last of those ticks.
- R4: Bit i of `bank_present_i` marks bank i as populated. Only populated banks get a reset request, in ascending index order. `rst_req_o` stays high, with `rst_bank_o` unchanged, until `rst_done_i` is seen. It then goes low for at least one cycle before the next bank's request.
- R5: `pwr_ready_o` rises one clock after the last populated bank's `rst_done_i` is seen with `rst_err_i` low. If the mask is all zero, it rises at the clock that takes the last settling tick.
- R6: If `rst_done_i` is seen together with `rst_err_i`, `fatal_o` is 1 from the next clock until `rst_n`. While it is set, no further reset requests are made, `pwr_ready_o` stays 0 and the rail stays on.
- R7: Idleness is evaluated only on a sampling strobe. The strobe falls on the `POLL_TICKS`-th tick after reset and on every `POLL_TICKS`-th tick after that. Between strobes the rail stays on however long the array has been idle.
- R8: At a strobe taken while powered up, the block counts the ticks received since the last refresh, not including the strobe's own tick. If that count exceeds `IDLE_TICKS`, then `rail_en_o`, `pad_en_o` and `pwr_ready_o` all fall at the same clock.
- R9: The idle count restarts at four points: an `act_i` pulse, the start of power-up, the end of settling, and the completion of power-up. A tick arriving in the same cycle as a refresh is not counted.
- R10: If `req_i` is still high when the rail drops, a new power-up starts at the next clock. `pwr_ready_o` returns only after that full sequence has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle time-base pulse |
| act_i | input | 1 | Pulse marking an access to the array |
| req_i | input | 1 | Access request, held high until served |
| bank_present_i | input | NUM_BANKS | Bit i set when bank i is populated |
| rst_done_i | input | 1 | Sequencer finished the requested bank reset |
| rst_err_i | input | 1 | Qualifies `rst_done_i` as a failed reset |
| rail_en_o | output | 1 | Supply rail enable |
| pad_en_o | output | 1 | Pads in active configuration (0 = low-power) |
| rst_req_o | output | 1 | Bank reset request to the sequencer |
| rst_bank_o | output | BANK_W | Index of the bank to reset |
| pwr_ready_o | output | 1 | Array powered and all populated banks reset |
| fatal_o | output | 1 | Sticky flag for a failed power-up reset |

## Verification
The hardest case to reach from the ports is the exact tick on which the rail drops. That tick depends on two things: the phase of the free-running sampling strobe, and how many ticks had passed since the last refresh. The bench keeps a running total of all ticks since reset and predicts the drop tick arithmetically. It powers the array up once for every possible present mask, so each power-up ends at a different strobe phase, and on alternate runs it inserts an activity pulse partway through the idle period. Two further cases are forced directly: holding a request across the drop edge, and reporting an error on a middle bank.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_SETTLE,
      ST_RST_REQ,
      ST_RST_GAP,
      ST_ON,
      ST_FAULT
   } fpm_state_e;

   function automatic int fpm_idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/fpm_poll_div.sv
module fpm_poll_div #(
   parameter int POLL_TICKS = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   output logic strobe_o
);
   localparam int CW = $clog2(POLL_TICKS);

   logic [CW-1:0] cnt_q;
   logic          wrap;

   assign wrap     = (cnt_q == CW'(POLL_TICKS - 1));
   assign strobe_o = tick_i & wrap;

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_i) cnt_q <= wrap ? '0 : cnt_q + CW'(1);
   end
endmodule

// File: rtl/fpm_idle_ctr.sv
module fpm_idle_ctr #(
   parameter int IDLE_TICKS = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic clr_i,
   output logic idle_o
);
   localparam int LIM = IDLE_TICKS + 1;
   localparam int CW  = $clog2(LIM + 1);

   logic [CW-1:0] cnt_q;

   assign idle_o = (cnt_q > CW'(IDLE_TICKS));

   always_ff @(posedge clk) begin
      if (!rst_n)                               cnt_q <= '0;
      else if (clr_i)                           cnt_q <= '0;
      else if (tick_i && cnt_q != CW'(LIM))     cnt_q <= cnt_q + CW'(1);
   end
endmodule

// File: rtl/fpm_bank_pick.sv
module fpm_bank_pick #(
   parameter int NUM_BANKS = 4,
   localparam int IW = fpm_pkg::fpm_idx_w(NUM_BANKS)
) (
   input  logic [NUM_BANKS-1:0] mask_i,
   input  logic [IW-1:0]        start_i,
   output logic                 found_o,
   output logic [IW-1:0]        idx_o
);
   logic [NUM_BANKS-1:0] elig;

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_elig
      assign elig[g] = mask_i[g] & (start_i <= IW'(g));
   end

   assign found_o = |elig;

   always_comb begin
      idx_o = '0;
      for (int i = NUM_BANKS - 1; i >= 0; i--) begin
         if (elig[i]) idx_o = IW'(i);
      end
   end
endmodule

// File: rtl/flash_idle_pwr.sv
module flash_idle_pwr
   import fpm_pkg::*;
#(
   parameter int NUM_BANKS    = 4,
   parameter int POLL_TICKS   = 100,
   parameter int IDLE_TICKS   = 200,
   parameter int SETTLE_TICKS = 50,
   localparam int BANK_W      = fpm_idx_w(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_i,
   input  logic                 act_i,
   input  logic                 req_i,
   input  logic [NUM_BANKS-1:0] bank_present_i,
   input  logic                 rst_done_i,
   input  logic                 rst_err_i,
   output logic                 rail_en_o,
   output logic                 pad_en_o,
   output logic                 rst_req_o,
   output logic [BANK_W-1:0]    rst_bank_o,
   output logic                 pwr_ready_o,
   output logic                 fatal_o
);
   localparam int SET_W = $clog2(SETTLE_TICKS + 1);

   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("flash_idle_pwr: NUM_BANKS must be at least 1");
   end
   if (POLL_TICKS < 2) begin : g_bad_poll
      $error("flash_idle_pwr: POLL_TICKS must be at least 2");
   end
   if (IDLE_TICKS < 1) begin : g_bad_idle
      $error("flash_idle_pwr: IDLE_TICKS must be at least 1");
   end
   if (SETTLE_TICKS < 1) begin : g_bad_settle
      $error("flash_idle_pwr: SETTLE_TICKS must be at least 1");
   end

   fpm_state_e        state_q, state_d;
   logic [BANK_W-1:0] bank_q, bank_d;
   logic [SET_W-1:0]  sc_q, sc_d;
   logic              fatal_q, fatal_d;

   logic              poll_stb;
   logic              idle_hit;
   logic              refresh;
   logic [BANK_W-1:0] pick_start;
   logic              pick_found;
   logic [BANK_W-1:0] pick_idx;
   logic              settle_done;
   logic              last_bank;
   logic              more_banks;
   logic              done_ok;

   fpm_poll_div #(.POLL_TICKS(POLL_TICKS)) u_poll (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .strobe_o (poll_stb)
   );

   fpm_idle_ctr #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .clr_i  (act_i | refresh),
      .idle_o (idle_hit)
   );

   fpm_bank_pick #(.NUM_BANKS(NUM_BANKS)) u_pick (
      .mask_i  (bank_present_i),
      .start_i (pick_start),
      .found_o (pick_found),
      .idx_o   (pick_idx)
   );

   assign pick_start  = (state_q == ST_SETTLE) ? '0 : bank_q + BANK_W'(1);
   assign settle_done = (state_q == ST_SETTLE) && tick_i &&
                        (sc_q == SET_W'(SETTLE_TICKS - 1));
   assign last_bank   = (bank_q == BANK_W'(NUM_BANKS - 1));
   assign more_banks  = pick_found && !last_bank;
   assign done_ok     = (state_q == ST_RST_REQ) && rst_done_i && !rst_err_i;
   assign refresh     = ((state_q == ST_OFF) && req_i) ||
                        (settle_done && !pick_found) || settle_done ||
                        (done_ok && !more_banks);

   always_comb begin
      state_d = state_q;
      bank_d  = bank_q;
      sc_d    = sc_q;
      fatal_d = fatal_q;
      unique case (state_q)
         ST_OFF: begin
            if (req_i) begin
               state_d = ST_SETTLE;
               sc_d    = '0;
            end
         end
         ST_SETTLE: begin
            if (settle_done) begin
               if (pick_found) begin
                  state_d = ST_RST_REQ;
                  bank_d  = pick_idx;
               end else begin
                  state_d = ST_ON;
               end
            end else if (tick_i) begin
               sc_d = sc_q + SET_W'(1);
            end
         end
         ST_RST_REQ: begin
            if (rst_done_i) begin
               if (rst_err_i) begin
                  state_d = ST_FAULT;
                  fatal_d = 1'b1;
               end else if (more_banks) begin
                  state_d = ST_RST_GAP;
                  bank_d  = pick_idx;
               end else begin
                  state_d = ST_ON;
               end
            end
         end
         ST_RST_GAP: state_d = ST_RST_REQ;
         ST_ON: begin
            if (poll_stb && idle_hit) state_d = ST_OFF;
         end
         ST_FAULT: state_d = ST_FAULT;
         default:  state_d = ST_OFF;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_OFF;
         bank_q  <= '0;
         sc_q    <= '0;
         fatal_q <= 1'b0;
      end else begin
         state_q <= state_d;
         bank_q  <= bank_d;
         sc_q    <= sc_d;
         fatal_q <= fatal_d;
      end
   end

   assign rail_en_o   = (state_q != ST_OFF);
   assign pad_en_o    = (state_q == ST_RST_REQ) || (state_q == ST_RST_GAP) ||
                        (state_q == ST_ON) || (state_q == ST_FAULT);
   assign rst_req_o   = (state_q == ST_RST_REQ);
   assign rst_bank_o  = bank_q;
   assign pwr_ready_o = (state_q == ST_ON);
   assign fatal_o     = fatal_q;
endmodule

// File: rtl/fpm_chk.sv
module fpm_chk #(
   parameter int NUM_BANKS = 4,
   localparam int BANK_W   = fpm_pkg::fpm_idx_w(NUM_BANKS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 poll_stb_i,
   input logic [NUM_BANKS-1:0] bank_present_i,
   input logic                 rst_done_i,
   input logic                 rail_en_o,
   input logic                 pad_en_o,
   input logic                 rst_req_o,
   input logic [BANK_W-1:0]    rst_bank_o,
   input logic                 pwr_ready_o,
   input logic                 fatal_o
);
   a_r5_ready_means_powered: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_ready_o |-> rail_en_o && pad_en_o && !rst_req_o);

   a_r4_req_targets_present: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> bank_present_i[rst_bank_o]);

   a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o && !rst_done_i |=> rst_req_o && $stable(rst_bank_o));

   a_r4_gap_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o && rst_done_i |=> !rst_req_o);

   a_r6_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      fatal_o |=> fatal_o && !pwr_ready_o && rail_en_o);

   a_r8_drop_together: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rail_en_o) |-> !pad_en_o && !pwr_ready_o && $past(pwr_ready_o));

   a_r7_drop_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rail_en_o) |-> $past(poll_stb_i));
endmodule

bind flash_idle_pwr fpm_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .poll_stb_i     (poll_stb),
   .bank_present_i (bank_present_i),
   .rst_done_i     (rst_done_i),
   .rail_en_o      (rail_en_o),
   .pad_en_o       (pad_en_o),
   .rst_req_o      (rst_req_o),
   .rst_bank_o     (rst_bank_o),
   .pwr_ready_o    (pwr_ready_o),
   .fatal_o        (fatal_o)
);

// File: tb/flash_idle_pwr_tb.sv
module flash_idle_pwr_tb;
   localparam int NB = 4, POLL = 4, IDLE = 6, SETTLE = 3;

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, act = 1'b0, req = 1'b0;
   logic done = 1'b0, err = 1'b0;
   logic [NB-1:0] mask = '0;
   logic rail, pad, rreq, ready, fatal;
   logic [1:0] bank;

   int nchk = 0, nerr = 0, g = 0, gref = 0;
   bit fin = 1'b0;

   always #5 clk = ~clk;

   flash_idle_pwr #(.NUM_BANKS(NB), .POLL_TICKS(POLL), .IDLE_TICKS(IDLE),
                    .SETTLE_TICKS(SETTLE)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .act_i(act), .req_i(req),
      .bank_present_i(mask), .rst_done_i(done), .rst_err_i(err),
      .rail_en_o(rail), .pad_en_o(pad), .rst_req_o(rreq), .rst_bank_o(bank),
      .pwr_ready_o(ready), .fatal_o(fatal));

   task automatic chk(input string rq, input int a, input int e);
      nchk++;
      if (a != e) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", rq, a, e);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic do_tick();
      tick = 1'b1;
      step();
      tick = 1'b0;
      g++;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; tick = 0; act = 0; req = 0; done = 0; err = 0;
      step(); step();
      rst_n = 1'b1;
      g = 0; gref = 0;
      step();
   endtask

   task automatic pu_finish(input logic [NB-1:0] m, input int errb);
      for (int k = 0; k < SETTLE; k++) begin
         chk("R3 pad low while settling", pad, 0);
         chk("R3 no reset while settling", rreq, 0);
         do_tick();
      end
      gref = g;
      chk("R3 pad up after settling", pad, 1);
      if (m == '0) begin
         chk("R5 ready with empty mask", ready, 1);
         chk("R4 no request with empty mask", rreq, 0);
         return;
      end
      for (int b = 0; b < NB; b++) begin
         if (m[b]) begin
            chk("R4 request raised", rreq, 1);
            chk("R4 bank order", int'(bank), b);
            chk("R5 not ready during resets", ready, 0);
            step();
            chk("R4 request held", rreq, 1);
            chk("R4 bank held", int'(bank), b);
            done = 1'b1; err = (b == errb);
            step();
            done = 1'b0; err = 1'b0;
            chk("R4 request drops after done", rreq, 0);
            if (b == errb) begin
               chk("R6 fatal set", fatal, 1);
               chk("R6 ready low on fault", ready, 0);
               return;
            end
            if ((int'(m) >> (b + 1)) != 0) begin
               chk("R5 not ready before last bank", ready, 0);
               step();
            end else begin
               chk("R5 ready after last bank", ready, 1);
            end
         end
      end
   endtask

   task automatic power_up(input logic [NB-1:0] m, input int errb);
      mask = m;
      chk("R2 rail off before request", rail, 0);
      req = 1'b1;
      step();
      chk("R2 rail up after request", rail, 1);
      chk("R2 pad low after request", pad, 0);
      chk("R2 ready low after request", ready, 0);
      pu_finish(m, errb);
      req = 1'b0;
   endtask

   task automatic idle_run(input bit act_mid, input bit hold_req, output bit dropped);
      dropped = 1'b0;
      if (hold_req) req = 1'b1;
      for (int k = 0; k < 60; k++) begin
         int gn;
         bit exp_drop;
         gn = g + 1;
         exp_drop = ((gn % POLL) == 0) && ((g - gref) > IDLE);
         do_tick();
         chk("R8 rail against idle prediction (R9 refresh)", rail, int'(!exp_drop));
         if (exp_drop) begin
            chk("R8 pad drops with rail", pad, 0);
            chk("R8 ready drops with rail", ready, 0);
            dropped = 1'b1;
            break;
         end
         chk("R7 ready kept between strobes", ready, 1);
         if (act_mid && k == 2) begin
            act = 1'b1;
            step();
            act = 1'b0;
            gref = g;
         end
      end
      if (!dropped) chk("R8 rail eventually dropped", 0, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!fin) begin
         nerr++;
         $display("FAIL R10 watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
         $finish;
      end
   end

   initial begin
      bit d;
      do_reset();
      chk("R1 rail after reset", rail, 0);
      chk("R1 pad after reset", pad, 0);
      chk("R1 request after reset", rreq, 0);
      chk("R1 bank after reset", int'(bank), 0);
      chk("R1 ready after reset", ready, 0);
      chk("R1 fatal after reset", fatal, 0);

      for (int m = 0; m < (1 << NB); m++) begin
         power_up(NB'(m), -1);
         idle_run(m[0], 1'b0, d);
      end

      power_up(4'b1010, -1);
      idle_run(1'b0, 1'b1, d);
      if (d) begin
         step();
         chk("R10 restart after drop", rail, 1);
         chk("R10 ready low during restart", ready, 0);
         pu_finish(4'b1010, -1);
         req = 1'b0;
         chk("R10 ready after full sequence", ready, 1);
         idle_run(1'b1, 1'b0, d);
      end

      do_reset();
      power_up(4'b1111, 2);
      for (int k = 0; k < 3 * (IDLE + POLL); k++) do_tick();
      done = 1'b1; step(); done = 1'b0; step();
      chk("R6 rail stays on", rail, 1);
      chk("R6 fatal sticky", fatal, 1);
      chk("R6 ready never rises", ready, 0);
      chk("R6 no further requests", rreq, 0);

      do_reset();
      chk("R1 fatal cleared by reset", fatal, 0);
      chk("R1 rail off after reset", rail, 0);

      fin = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule